// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator

This block generates up to four independent active-high pulse-width modulated outputs from one shared source clock. Each channel owns a single 32-bit control word, written and read over a plain memory-mapped bus with a combinational read port. The control word carries a frequency-division field, an 8-bit duty value, a force-high bit and a run bit.

A running channel first slows the source clock by a programmable divisor. It then counts 256 of the slowed ticks per output period and holds its output high for the first duty ticks of every period. Any write to a channel's word, including a write that clears the run bit, acts on the very next clock. The period already in progress is thrown away and both counters restart from zero.

Top module: `pwm_bank`

## Requirements
- R1: After reset every control word reads as zero and every output is low.
- R2: Address bits [5:4] pick the channel and all other address bits must be zero. A read returns the last word written to that channel. An address that is misaligned, or that names a channel at or above NUM_CH, reads zero and its writes change nothing.
- R3: Bits [12:0] hold the divide field F. One tick of the period counter lasts F+1 source clock cycles, so F=0 gives one tick per clock.
- R4: An output period is 256 ticks long. With bit 24 clear the output is high during ticks 0 to D-1 of each period and low for the rest, where D is bits [23:16].
- R5: With bit 24 clear and D=0 the output stays low for the whole period.
- R6: With bit 24 set the output is high for every tick of the period, whatever D holds.
- R7: Bit 31 enables the channel. A write that clears it drives the output low from the next clock edge on, in the middle of a period if need be.
- R8: A write to a running channel restarts its divider and tick counter at zero on that clock edge, so the new settings govern the output from the next cycle on.
- R9: Channels run independently. A write to one channel does not disturb the output or the counters of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, shared by all channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address of the control word |
| bus_wen | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH | One modulated output per channel |

## Verification
The bench builds the block with NUM_CH=3. This leaves address slot 3 unpopulated, so reads and writes to a missing channel can be observed at the ports alongside the usual misaligned addresses. The divide field stays at the default 13-bit width. Random runs program only small divisors (0 to 3), so that full 256-tick periods, and the wrap into the next period, fit in short windows. Read-back still uses values that exercise all 13 bits of the field.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NUM_CH  = 4,
  parameter int SCALE_W = 13,
  parameter int DUTY_W  = 8,
  parameter int AW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wen,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int SEL_LO   = 4;
  localparam int DUTY_LO  = 16;
  localparam int FULL_BIT = 24;
  localparam int RUN_BIT  = 31;

  logic [NUM_CH-1:0][31:0]        ctl_q;
  logic [NUM_CH-1:0][SCALE_W-1:0] presc_q;
  logic [NUM_CH-1:0][DUTY_W-1:0]  tick_q;
  logic [NUM_CH-1:0]              hit;

  wire       aligned = (bus_addr & ~(AW'(3) << SEL_LO)) == '0;
  wire [1:0] sel     = bus_addr[SEL_LO +: 2];

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      hit[c] = aligned && (sel == 2'(c));
      if (hit[c]) bus_rdata = ctl_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      presc_q <= '0;
      tick_q  <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (bus_wen && hit[c]) begin
          ctl_q[c]   <= bus_wdata;
          presc_q[c] <= '0;
          tick_q[c]  <= '0;
        end else if (ctl_q[c][RUN_BIT]) begin
          if (presc_q[c] == ctl_q[c][SCALE_W-1:0]) begin
            presc_q[c] <= '0;
            tick_q[c]  <= tick_q[c] + 1'b1;
          end else begin
            presc_q[c] <= presc_q[c] + 1'b1;
          end
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign pwm_out[c] = ctl_q[c][RUN_BIT] &&
                        (ctl_q[c][FULL_BIT] || (tick_q[c] < ctl_q[c][DUTY_LO +: DUTY_W]));

    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && hit[c]) |=> (ctl_q[c] == $past(bus_wdata)));

    assert_presc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[c][RUN_BIT] |-> (presc_q[c] <= ctl_q[c][SCALE_W-1:0]));

    assert_tick_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_wen && hit[c]) && ctl_q[c][RUN_BIT]) |=>
        (tick_q[c] == $past(tick_q[c]) || tick_q[c] == $past(tick_q[c]) + 1'b1));

    assert_full_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && hit[c] && bus_wdata[RUN_BIT] && bus_wdata[FULL_BIT]) |=> pwm_out[c]);

    assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && hit[c] && !bus_wdata[RUN_BIT]) |=> !pwm_out[c]);

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && hit[c]) |=> (presc_q[c] == '0 && tick_q[c] == '0));

    assert_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && !hit[c]) |=> (ctl_q[c] == $past(ctl_q[c])));
  end
endmodule

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
  localparam int NCH = 3;
  localparam int AW  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wen = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  pwm_out;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_ctl [NCH];
  int          m_cnt [NCH];

  always #2.5 clk = ~clk;

  pwm_bank #(.NUM_CH(NCH), .SCALE_W(13), .DUTY_W(8), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  function automatic int slot_of(input logic [AW-1:0] a);
    if (a[3:0] != 0 || a[AW-1:6] != 0) return -1;
    if (int'(a[5:4]) >= NCH) return -1;
    return int'(a[5:4]);
  endfunction

  function automatic logic expect_out(input logic [31:0] w, input int cnt);
    int tick;
    if (!w[31]) return 1'b0;
    if (w[24]) return 1'b1;
    tick = (cnt / (int'(w[12:0]) + 1)) % 256;
    return tick < int'(w[23:16]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin m_ctl[c] <= '0; m_cnt[c] <= 0; end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (bus_wen && slot_of(bus_addr) == c) begin
          m_ctl[c] <= bus_wdata; m_cnt[c] <= 0;
        end else if (m_ctl[c][31]) m_cnt[c] <= m_cnt[c] + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd_check(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    check(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  task automatic watch(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < NCH; c++)
        check(pwm_out[c] == expect_out(m_ctl[c], m_cnt[c]), req, pwm_out[c],
              expect_out(m_ctl[c], m_cnt[c]));
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] word(input bit run, input bit full, input int duty, input int f);
    return {run, 6'd0, full, 8'(duty), 3'd0, 13'(f)};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check(pwm_out == '0, "R1", pwm_out, 0);
    rst_n = 1'b1;
    for (int c = 0; c < NCH; c++) rd_check(AW'(c << 4), 32'h0, "R1");
    watch(4, "R1");

    wr(8'h10, 32'h7ABC_1FFF);
    rd_check(8'h10, 32'h7ABC_1FFF, "R2");
    wr(8'h14, 32'hFFFF_FFFF);
    rd_check(8'h14, 32'h0, "R2");
    rd_check(8'h10, 32'h7ABC_1FFF, "R2");
    wr(8'h30, 32'h8100_0000);
    rd_check(8'h30, 32'h0, "R2");
    wr(8'h50, 32'h8100_0000);
    rd_check(8'h10, 32'h7ABC_1FFF, "R2");
    check(pwm_out == '0, "R2", pwm_out, 0);

    wr(8'h00, word(1, 0, 128, 0));
    watch(300, "R4");
    wr(8'h10, word(1, 0, 1, 2));
    watch(800, "R3");
    wr(8'h20, word(1, 0, 0, 0));
    watch(300, "R5");
    wr(8'h20, word(1, 1, 16, 0));
    watch(300, "R6");

    wr(8'h00, word(1, 0, 200, 0));
    repeat (50) @(negedge clk);
    bus_addr = 8'h00; bus_wdata = word(0, 0, 200, 0); bus_wen = 1'b1;
    @(negedge clk); bus_wen = 1'b0;
    check(pwm_out[0] == 1'b0, "R7", pwm_out[0], 0);
    watch(20, "R7");

    wr(8'h10, word(1, 0, 100, 0));
    repeat (150) @(negedge clk);
    check(pwm_out[1] == 1'b0, "R8", pwm_out[1], 0);
    bus_addr = 8'h10; bus_wdata = word(1, 0, 100, 0); bus_wen = 1'b1;
    @(negedge clk); bus_wen = 1'b0;
    check(pwm_out[1] == 1'b1, "R8", pwm_out[1], 1);
    watch(120, "R8");

    for (int it = 0; it < 24; it++) begin
      int c;
      c = int'($urandom_range(0, NCH - 1));
      wr(AW'(c << 4), word($urandom_range(0, 5) != 0, $urandom_range(0, 7) == 0,
                           int'($urandom_range(0, 255)), int'($urandom_range(0, 3))));
      watch(int'($urandom_range(100, 600)), "R9");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule